// File: doc/BRIEF.md
# Line Remote Defect Indication Generator with Minimum Hold

This block decides, once per frame, whether the transmit side should request a line remote defect indication toward the far end. Seven receive-side defect levels each pass through their own enable gate, and any surviving term raises the request. The defects are loss of clock, loss of signal, loss of frame, out of frame, incoming line AIS, signal fail and signal degrade. A select bit lets a redundant (protection) board supply the request in place of the local receive side.

Whatever the source, the request is stretched. Once raised, the output stays high for a whole number of frames, `HOLD_FRAMES` (20 by default), after the last frame in which the source was active. A short defect therefore still produces an indication that is long enough to be seen. All inputs are sampled only on clock edges where the frame strobe is high, so the hold is measured in frames and not in clock cycles. Detecting the defects and building the overhead byte are left to neighbouring blocks.

Top module: `line_rdi_gen`

## Requirements
- R1: While reset (`rstN` low, asynchronous) is applied, and after it is released, the hold count is zero and `rdiReq` is 0. The output stays 0 until an active request is sampled.
- R2: Defect bit i contributes to the local request only when enable bit i is 1. Bit positions: 0 loss of clock, 1 loss of signal, 2 loss of frame, 3 out of frame, 4 line AIS, 5 signal fail, 6 signal degrade.
- R3: With `selProt` = 0 the request is the OR of all enabled defect bits, and `protRdi` has no effect.
- R4: With `selProt` = 1 the request equals `protRdi`, and the defect and enable inputs have no effect.
- R5: Inputs are sampled only on rising clock edges with `frameStb` = 1. On any other edge `rdiReq` keeps its value and the hold count does not move.
- R6: A strobe edge that samples an active request sets `rdiReq` to 1 from the next cycle.
- R7: After the last active strobe, `rdiReq` stays 1 through the next `HOLD_FRAMES`-1 inactive strobes. It falls to 0 on the `HOLD_FRAMES`-th inactive strobe, and it falls on no other kind of edge.
- R8: An active strobe during the hold reloads the full `HOLD_FRAMES` count, no matter how much of the hold has already passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStb | input | 1 | One-cycle frame boundary strobe; qualifies sampling |
| defectLvl | input | NUM_DEFECTS (7) | Receive defect levels, bit order as in R2 |
| defectEn | input | NUM_DEFECTS (7) | Per-defect enable for the request |
| protRdi | input | 1 | Request coming from the protection board |
| selProt | input | 1 | 1 selects `protRdi`, 0 selects the local defects |
| rdiReq | output | 1 | Stretched line RDI request |

## Verification
The bench sweeps all 128 enable masks against an idle level, each single defect and all defects together. This catches a term wired to the wrong enable bit or a term that ignores its enable, because either would raise the request when it should stay quiet. It counts inactive strobes until the output falls: an off-by-one hold releases after 19 or 21 frames, and a counter that also decrements on non-strobe cycles releases within a few clock cycles. Retriggering in the middle of a hold exposes a counter that fails to reload, which releases early. The bench also checks that each source is ignored while the other is selected, so an inverted or leaky mux shows up as a request that should not be there.

// File: rtl/lrdi_pkg.sv
package lrdi_pkg;

  // Bit positions of the receive defect vector.
  typedef enum int {
    DEF_LOSS_CLOCK  = 0,
    DEF_LOSS_SIGNAL = 1,
    DEF_LOSS_FRAME  = 2,
    DEF_OUT_FRAME   = 3,
    DEF_LINE_AIS    = 4,
    DEF_SIG_FAIL    = 5,
    DEF_SIG_DEGRADE = 6
  } defectIdx_e;

  // Strobes from control to the hold datapath.
  typedef struct packed {
    logic reload;     // active request sampled: restart hold
    logic countDown;  // inactive strobe while hold running
  } holdCmd_t;

endpackage

// File: rtl/lrdi_ctrl.sv
module lrdi_ctrl
  import lrdi_pkg::*;
(
  input  logic     frameStb,
  input  logic     rawReq,
  input  logic     cntIsZero,
  output holdCmd_t cmd
);

  // Only frame strobe edges may change the hold state.
  always_comb begin
    cmd           = '0;
    cmd.reload    = frameStb & rawReq;
    cmd.countDown = frameStb & ~rawReq & ~cntIsZero;
  end

endmodule

// File: rtl/lrdi_datapath.sv
module lrdi_datapath
  import lrdi_pkg::*;
#(
  parameter int NUM_DEFECTS = 7,
  parameter int HOLD_FRAMES = 20
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_DEFECTS-1:0] defectLvl,
  input  logic [NUM_DEFECTS-1:0] defectEn,
  input  logic                   protRdi,
  input  logic                   selProt,
  input  holdCmd_t               cmd,
  output logic                   rawReq,
  output logic                   cntIsZero,
  output logic                   rdiReq
);

  localparam int CNT_W = $clog2(HOLD_FRAMES + 1);
  localparam logic [CNT_W-1:0] HOLD_VAL = CNT_W'(HOLD_FRAMES);
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(1);

  logic [NUM_DEFECTS-1:0] qualTerm;
  logic                   localReq;
  logic [CNT_W-1:0]       holdCnt;
  logic                   rdiQ;

  // One gate per defect term.
  for (genvar i = 0; i < NUM_DEFECTS; i++) begin : g_qual
    assign qualTerm[i] = defectLvl[i] & defectEn[i];
  end

  assign localReq  = |qualTerm;
  assign rawReq    = selProt ? protRdi : localReq;
  assign cntIsZero = (holdCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (cmd.reload) begin
      holdCnt <= HOLD_VAL;
    end else if (cmd.countDown) begin
      holdCnt <= holdCnt - LAST_VAL;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdiQ <= 1'b0;
    end else if (cmd.reload) begin
      rdiQ <= 1'b1;
    end else if (cmd.countDown && holdCnt == LAST_VAL) begin
      rdiQ <= 1'b0;
    end
  end

  assign rdiReq = rdiQ;

endmodule

// File: rtl/line_rdi_gen.sv
module line_rdi_gen
  import lrdi_pkg::*;
#(
  parameter int NUM_DEFECTS = 7,
  parameter int HOLD_FRAMES = 20
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   frameStb,
  input  logic [NUM_DEFECTS-1:0] defectLvl,
  input  logic [NUM_DEFECTS-1:0] defectEn,
  input  logic                   protRdi,
  input  logic                   selProt,
  output logic                   rdiReq
);

  holdCmd_t holdCmd;
  logic     rawReq;
  logic     cntIsZero;

  lrdi_ctrl u_ctrl (
    .frameStb (frameStb),
    .rawReq   (rawReq),
    .cntIsZero(cntIsZero),
    .cmd      (holdCmd)
  );

  lrdi_datapath #(
    .NUM_DEFECTS(NUM_DEFECTS),
    .HOLD_FRAMES(HOLD_FRAMES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .defectLvl(defectLvl),
    .defectEn (defectEn),
    .protRdi  (protRdi),
    .selProt  (selProt),
    .cmd      (holdCmd),
    .rawReq   (rawReq),
    .cntIsZero(cntIsZero),
    .rdiReq   (rdiReq)
  );

endmodule

// File: rtl/line_rdi_gen_chk.sv
module line_rdi_gen_chk #(
  parameter int NUM_DEFECTS = 7,
  parameter int HOLD_FRAMES = 20
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   frameStb,
  input logic [NUM_DEFECTS-1:0] defectLvl,
  input logic [NUM_DEFECTS-1:0] defectEn,
  input logic                   protRdi,
  input logic                   selProt,
  input logic                   rdiReq
);

  localparam int GAP_W = $clog2(HOLD_FRAMES + 1);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(HOLD_FRAMES);

  logic             localAny;
  logic             srcReq;
  logic             seenActive;
  logic [GAP_W-1:0] gapFrames;

  assign localAny = |(defectLvl & defectEn);
  assign srcReq   = selProt ? protRdi : localAny;

  // Inactive strobes since the last active strobe, saturating.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenActive <= 1'b0;
      gapFrames  <= '0;
    end else if (frameStb) begin
      if (srcReq) begin
        seenActive <= 1'b1;
        gapFrames  <= '0;
      end else if (gapFrames < GAP_MAX) begin
        gapFrames <= gapFrames + GAP_W'(1);
      end
    end
  end

  // R1
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> !rdiReq);

  assert_enabled_term_R2: assert property (@(posedge clk) disable iff (!rstN)
    (frameStb && !selProt && localAny) |=> rdiReq);

  assert_prot_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!rdiReq && frameStb && !selProt && !localAny) |=> !rdiReq);

  assert_local_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!rdiReq && frameStb && selProt && !protRdi) |=> !rdiReq);

  assert_quiet_between_R5: assert property (@(posedge clk) disable iff (!rstN)
    !frameStb |=> $stable(rdiReq));

  assert_active_sets_R6: assert property (@(posedge clk) disable iff (!rstN)
    (frameStb && srcReq) |=> rdiReq);

  assert_fall_on_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdiReq) |-> ($past(frameStb) && !$past(srcReq)));

  assert_hold_window_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdiReq == (seenActive && (gapFrames < GAP_MAX)));

endmodule

bind line_rdi_gen line_rdi_gen_chk #(
  .NUM_DEFECTS(NUM_DEFECTS),
  .HOLD_FRAMES(HOLD_FRAMES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .frameStb (frameStb),
  .defectLvl(defectLvl),
  .defectEn (defectEn),
  .protRdi  (protRdi),
  .selProt  (selProt),
  .rdiReq   (rdiReq)
);

// File: tb/line_rdi_gen_tb.sv
`timescale 1ns/1ps
module line_rdi_gen_tb;

  localparam int ND   = 7;
  localparam int HOLD = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          frameStb = 1'b0;
  logic [ND-1:0] defectLvl = '0;
  logic [ND-1:0] defectEn = '0;
  logic          protRdi = 1'b0;
  logic          selProt = 1'b0;
  logic          rdiReq;

  int  nCmp = 0;
  int  nBad = 0;
  int  expHold = 0;
  bit  finished = 0;

  always #4 clk = ~clk;

  line_rdi_gen #(.NUM_DEFECTS(ND), .HOLD_FRAMES(HOLD)) u_dut (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .defectLvl(defectLvl),
    .defectEn(defectEn), .protRdi(protRdi), .selProt(selProt), .rdiReq(rdiReq)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: rdiReq=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // One strobe cycle; called at a falling edge, returns at the next one.
  task automatic strobe(input string tag, input logic [ND-1:0] lvl,
                        input logic [ND-1:0] en, input logic prot, input logic sel);
    logic raw;
    defectLvl = lvl; defectEn = en; protRdi = prot; selProt = sel;
    frameStb = 1'b1;
    raw = sel ? prot : |(lvl & en);
    @(negedge clk);
    if (raw) expHold = HOLD;
    else if (expHold > 0) expHold--;
    check(tag, rdiReq, expHold != 0);
  endtask

  // Non-strobe cycles with noisy inputs: nothing may change.
  task automatic idle(input string tag, input int n);
    for (int k = 0; k < n; k++) begin
      frameStb = 1'b0;
      defectLvl = '1; defectEn = '1; protRdi = 1'b1; selProt = k[0];
      @(negedge clk);
      check(tag, rdiReq, expHold != 0);
    end
  endtask

  task automatic drain(input string tag);
    while (expHold != 0) strobe(tag, '0, '0, 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    check("R1 in reset", rdiReq, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", rdiReq, 1'b0);
    idle("R1 idle after reset", 4);

    // R2/R3: every enable mask against idle, single and full defect sets.
    for (int en = 0; en < (1 << ND); en++) begin
      strobe("R2 zero level", '0, ND'(en), 1'b1, 1'b0);
      for (int b = 0; b < ND; b++) begin
        strobe("R2 single defect", ND'(1 << b), ND'(en), 1'b1, 1'b0);
        drain("R7 drain");
      end
      strobe("R3 all defects", '1, ND'(en), 1'b0, 1'b0);
      drain("R7 drain");
    end

    // R4: protection source selected.
    strobe("R4 local ignored", '1, '1, 1'b0, 1'b1);
    strobe("R4 prot active", '0, '0, 1'b1, 1'b1);
    drain("R4 drain");
    strobe("R3 prot ignored", '0, '1, 1'b1, 1'b0);

    // R7: exact hold length in inactive strobes.
    strobe("R6 set", 7'b0010000, 7'b0010000, 1'b0, 1'b0);
    cnt = 0;
    while (rdiReq && cnt < HOLD + 5) begin
      strobe("R7 hold", '0, '1, 1'b0, 1'b0);
      cnt++;
    end
    nCmp++;
    if (cnt != HOLD) begin
      nBad++;
      $display("FAIL R7: hold strobes=%0d expected=%0d", cnt, HOLD);
    end

    // R5: non-strobe cycles do not advance the hold.
    strobe("R6 set", '0, '0, 1'b1, 1'b1);
    for (int k = 0; k < 5; k++) strobe("R7 partial", '0, '0, 1'b0, 1'b0);
    idle("R5 no advance", 60);
    drain("R5 drain");
    idle("R5 stays low", 10);

    // R8: retrigger mid-hold restarts the full count.
    strobe("R8 first", 7'b1000000, 7'b1000000, 1'b0, 1'b0);
    for (int k = 0; k < 12; k++) strobe("R8 partial", '0, '0, 1'b0, 1'b0);
    strobe("R8 retrigger", 7'b0000001, 7'b0000001, 1'b0, 1'b0);
    cnt = 0;
    while (rdiReq && cnt < HOLD + 5) begin
      strobe("R8 hold", '0, '0, 1'b0, 1'b0);
      cnt++;
    end
    nCmp++;
    if (cnt != HOLD) begin
      nBad++;
      $display("FAIL R8: hold strobes=%0d expected=%0d", cnt, HOLD);
    end

    // R1: reset in the middle of a hold clears the output.
    strobe("R6 set", '1, '1, 1'b0, 1'b0);
    rstN = 1'b0;
    expHold = 0;
    @(negedge clk);
    check("R1 mid-hold reset", rdiReq, 1'b0);
    rstN = 1'b1;
    strobe("R1 post reset", '0, '0, 1'b0, 1'b0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule